// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a small timer peripheral with a configurable number of independent down-counting channels. A simple synchronous register bus reaches all of its state. Each channel keeps a current count, a reload constant and a control word. A shared run register, with one bit per channel, decides which channels are counting. A counting channel steps down once per prescaled tick, where the tick is taken from the block clock through a power-of-four divider that the channel selects for itself.

A tick that arrives while the count is zero is an underflow. On that tick the channel copies its reload constant into the count, and counting goes on from that value. The same tick sets a sticky underflow flag, which software clears by writing zero to it. When the channel's enable bit is set, its interrupt line is high for as long as the flag is set. A reload constant of all ones gives a free-running wrapping counter, which software can invert to get an up-counting timestamp. A reload constant of zero makes the channel a one-shot that stays at zero after it fires.

Top module: `dntimer_top`

## Requirements
- R1: After reset every count and every reload register reads all ones, every control word reads 0, the run register reads 0 and every interrupt output is low.
- R2: On each tick a running channel decrements its count by one. A tick at count 0 is an underflow: it loads the reload value and sets the flag, and the following ticks decrement from the loaded value.
- R3: Bit n of the run register (address 0x00) runs channel n. While the bit is clear, that channel's count holds its value.
- R4: Control bits [2:0] hold a select value s, and a tick comes every 4<<(2*s) clocks. A write that sets a clear run bit restarts that channel's divider, so the first tick lands exactly one full period after the write edge.
- R5: Control bit 8 is the underflow flag. Writing 0 to it clears it and writing 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R6: Control bit 5 is the interrupt enable. The channel's irq output is high exactly while both the flag and the enable are set.
- R7: A write to the count takes effect at once and is read back in the next cycle, even while the channel runs. It wins over a decrement or reload in the same cycle.
- R8: With reload all ones, a count of 0 wraps to 0xFFFFFFFF on the next tick.
- R9: With reload zero, after the first underflow the count stays at 0.
- R10: Channel n sits at base 0x10*(n+1), with the count at +0, the reload at +4 and the control word at +8. Control bits other than 8, 5 and 2:0 read 0. Any other address reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the prescaled ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register, combinational |
| irq | output | NUM_CH | Level interrupt, one per channel |

## Verification
The bench builds the block with three channels, 32-bit counters, 3-bit select fields and 8-bit addresses. Three channels cover a run bit above bit 1 and put slot 4 (0x40) just beyond the last channel, which exercises the unmapped-address rule. Divide-by-4 and divide-by-16 keep underflows, the wrap through all ones and the collision of a clearing write with an underflow within a few dozen cycles. A behavioural model that runs beside the design checks the addressed read data and the interrupt lines on every cycle.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
    localparam int SLOT_LSB      = 4;
    localparam int CTRL_IEN_BIT  = 5;
    localparam int CTRL_FLAG_BIT = 8;

    typedef enum logic [1:0] {
        WORD_COUNT  = 2'd0,
        WORD_RELOAD = 2'd1,
        WORD_CTRL   = 2'd2,
        WORD_SPARE  = 2'd3
    } word_e;
endpackage

// File: rtl/dntimer_prescale.sv
module dntimer_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = 2 * (2 ** SEL_W);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PRE_W-1:0] limit;
    int shamt;

    always_comb begin
        shamt = 2 + 2 * int'(sel);
        limit = ~({PRE_W{1'b1}} << shamt);
        tick  = run && (s_q.pre >= limit);
        s_d   = s_q;
        if (restart) begin
            s_d.pre = '0;
        end else if (tick) begin
            s_d.pre = '0;
        end else if (run) begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dntimer_chan.sv
module dntimer_chan
    import dntimer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             rel_we,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic [SEL_W-1:0] sel,
    output logic             ien,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic [SEL_W-1:0] sel;
        logic             ien;
        logic             flag;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        uflow;

    always_comb begin
        s_d   = s_q;
        uflow = tick && (s_q.count == '0);
        if (tick) begin
            s_d.count = uflow ? s_q.reload : (s_q.count - CNT_W'(1));
        end
        if (cnt_we) begin
            s_d.count = wdata;
        end
        if (rel_we) begin
            s_d.reload = wdata;
        end
        if (ctl_we) begin
            s_d.sel  = wdata[SEL_W-1:0];
            s_d.ien  = wdata[CTRL_IEN_BIT];
            s_d.flag = s_q.flag & wdata[CTRL_FLAG_BIT];
        end
        if (uflow) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count  <= '1;
            s_q.reload <= '1;
            s_q.sel    <= '0;
            s_q.ien    <= 1'b0;
            s_q.flag   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count  = s_q.count;
    assign reload = s_q.reload;
    assign sel    = s_q.sel;
    assign ien    = s_q.ien;
    assign flag   = s_q.flag;
endmodule

// File: rtl/dntimer_top.sv
module dntimer_top
    import dntimer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int SLOT_W = ADDR_W - SLOT_LSB;

    typedef struct packed {
        logic [NUM_CH-1:0] run;
    } run_state_t;

    run_state_t r_d, r_q;

    logic [SLOT_W-1:0] slot;
    word_e             word;
    logic              aligned;
    logic              start_sel;
    logic              start_hit;
    logic [NUM_CH-1:0] restart;
    logic [NUM_CH-1:0] run_vec;
    logic [NUM_CH-1:0] ch_tick;
    logic [NUM_CH-1:0] ch_flag;
    logic [CNT_W-1:0]  ch_count  [NUM_CH];
    logic [CNT_W-1:0]  ch_reload [NUM_CH];
    logic [CNT_W-1:0]  rd_part   [NUM_CH];

    function automatic logic [CNT_W-1:0] pick_word(
        input word_e            w,
        input logic [CNT_W-1:0] cnt,
        input logic [CNT_W-1:0] rel,
        input logic [CNT_W-1:0] ctl
    );
        case (w)
            WORD_COUNT:  return cnt;
            WORD_RELOAD: return rel;
            WORD_CTRL:   return ctl;
            default:     return '0;
        endcase
    endfunction

    assign slot      = bus_addr[ADDR_W-1:SLOT_LSB];
    assign word      = word_e'(bus_addr[3:2]);
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign start_sel = aligned && (slot == '0) && (word == WORD_COUNT);
    assign start_hit = bus_we && start_sel;
    assign restart   = start_hit ? (bus_wdata[NUM_CH-1:0] & ~r_q.run) : '0;
    assign run_vec   = r_q.run;

    always_comb begin
        r_d = r_q;
        if (start_hit) begin
            r_d.run = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             hit;
        logic             cnt_we;
        logic             rel_we;
        logic             ctl_we;
        logic [SEL_W-1:0] sel;
        logic             ien;
        logic [CNT_W-1:0] ctrl_word;

        assign hit    = aligned && (slot == SLOT_W'(g + 1));
        assign cnt_we = bus_we && hit && (word == WORD_COUNT);
        assign rel_we = bus_we && hit && (word == WORD_RELOAD);
        assign ctl_we = bus_we && hit && (word == WORD_CTRL);

        dntimer_prescale #(
            .SEL_W (SEL_W)
        ) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (r_q.run[g]),
            .restart (restart[g]),
            .sel     (sel),
            .tick    (ch_tick[g])
        );

        dntimer_chan #(
            .CNT_W (CNT_W),
            .SEL_W (SEL_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (ch_tick[g]),
            .cnt_we (cnt_we),
            .rel_we (rel_we),
            .ctl_we (ctl_we),
            .wdata  (bus_wdata),
            .count  (ch_count[g]),
            .reload (ch_reload[g]),
            .sel    (sel),
            .ien    (ien),
            .flag   (ch_flag[g])
        );

        always_comb begin
            ctrl_word                = '0;
            ctrl_word[SEL_W-1:0]     = sel;
            ctrl_word[CTRL_IEN_BIT]  = ien;
            ctrl_word[CTRL_FLAG_BIT] = ch_flag[g];
        end

        assign rd_part[g] = hit ? pick_word(word, ch_count[g], ch_reload[g], ctrl_word) : '0;
        assign irq[g]     = ch_flag[g] & ien;
    end

    always_comb begin
        bus_rdata = '0;
        if (start_sel) begin
            bus_rdata = CNT_W'(r_q.run);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            bus_rdata = bus_rdata | rd_part[i];
        end
    end
endmodule

// File: rtl/dntimer_chk.sv
module dntimer_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] run_vec,
    input logic [NUM_CH-1:0] ch_tick,
    input logic [NUM_CH-1:0] ch_flag,
    input logic [CNT_W-1:0]  ch_count  [NUM_CH],
    input logic [CNT_W-1:0]  ch_reload [NUM_CH]
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic cw;
        logic kw;
        logic at_zero;

        assign cw      = bus_we && (bus_addr == ADDR_W'((g + 1) * 16));
        assign kw      = bus_we && (bus_addr == ADDR_W'((g + 1) * 16 + 8));
        assign at_zero = (ch_count[g] == '0);

        assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[g] && !cw) |=> $stable(ch_count[g]));

        assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[g] && !at_zero && !cw) |=> (ch_count[g] == $past(ch_count[g]) - CNT_W'(1)));

        assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[g] && at_zero && !cw) |=> (ch_count[g] == $past(ch_reload[g])));

        assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[g] && at_zero) |=> ch_flag[g]);

        assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_flag[g] && !kw) |=> ch_flag[g]);

        assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (kw && !bus_wdata[8] && !(ch_tick[g] && at_zero)) |=> !ch_flag[g]);

        assert_first_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_vec[g]) |-> !ch_tick[g]);

        assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !kw) |=> irq[g]);

        assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_flag[g]) |-> !irq[g]);
    end
endmodule

bind dntimer_top dntimer_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run_vec   (run_vec),
    .ch_tick   (ch_tick),
    .ch_flag   (ch_flag),
    .ch_count  (ch_count),
    .ch_reload (ch_reload)
);

// File: tb/sim_dntimer_top.sv
`timescale 1ns/1ps
module sim_dntimer_top;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_cnt  [NCH];
    logic [31:0] m_rel  [NCH];
    int          m_sel  [NCH];
    int          m_pre  [NCH];
    bit          m_ien  [NCH];
    bit          m_flag [NCH];
    bit          m_run  [NCH];

    always #10 clk = ~clk;

    dntimer_top #(.NUM_CH(NCH), .CNT_W(32), .SEL_W(3), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on every clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = '1; m_rel[c] = '1; m_sel[c] = 0; m_pre[c] = 0;
                m_ien[c] = 0; m_flag[c] = 0; m_run[c] = 0;
            end
        end else begin
            bit wr_start;
            wr_start = bus_we && (bus_addr == 8'h00);
            for (int c = 0; c < NCH; c++) begin
                int  base;
                bit  tk, uf;
                base = 16 * (c + 1);
                tk = m_run[c] && (m_pre[c] >= (4 << (2 * m_sel[c])) - 1);
                uf = tk && (m_cnt[c] == 0);
                if (wr_start && bus_wdata[c] && !m_run[c]) m_pre[c] = 0;
                else if (tk) m_pre[c] = 0;
                else if (m_run[c]) m_pre[c] = m_pre[c] + 1;
                if (wr_start) m_run[c] = bus_wdata[c];
                if (bus_we && bus_addr == 8'(base)) m_cnt[c] = bus_wdata;
                else if (tk) m_cnt[c] = uf ? m_rel[c] : m_cnt[c] - 1;
                if (bus_we && bus_addr == 8'(base + 4)) m_rel[c] = bus_wdata;
                if (bus_we && bus_addr == 8'(base + 8)) begin
                    m_sel[c]  = int'(bus_wdata[2:0]);
                    m_ien[c]  = bus_wdata[5];
                    m_flag[c] = m_flag[c] & bus_wdata[8];
                end
                if (uf) m_flag[c] = 1'b1;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 8'h00) v = {29'd0, m_run[2], m_run[1], m_run[0]};
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'(16 * (c + 1)))     v = m_cnt[c];
            if (a == 8'(16 * (c + 1) + 4)) v = m_rel[c];
            if (a == 8'(16 * (c + 1) + 8)) v = {23'd0, m_flag[c], 2'b00, m_ien[c], 2'b00, 3'(m_sel[c])};
        end
        return v;
    endfunction

    function automatic string m_tag(input logic [7:0] a);
        if (a == 8'h00) return "R3 model run";
        if (a[1:0] != 2'b00 || a[7:4] > 4'd3 || a[7:4] == 4'd0 || a[3:2] == 2'd3) return "R10 model unmapped";
        if (a[3:2] == 2'd0) return "R2 model count";
        if (a[3:2] == 2'd1) return "R10 model reload";
        return "R5 model ctrl";
    endfunction

    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk(m_tag(bus_addr), bus_rdata, m_read(bus_addr));
            chk("R6 model irq", {29'd0, irq}, {29'd0, m_flag[2] & m_ien[2], m_flag[1] & m_ien[1], m_flag[0] & m_ien[0]});
        end
    end

    logic [31:0] got;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #5;
        bus_we = 1'b0;
        #1;
        got = bus_rdata;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        #6;
        got = bus_rdata;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v1;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(8'h00); chk("R1 run reg", got, 32'h0);
        chk("R1 irq", {29'd0, irq}, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            rd(8'(16 * (c + 1)));     chk("R1 count", got, 32'hFFFF_FFFF);
            rd(8'(16 * (c + 1) + 4)); chk("R1 reload", got, 32'hFFFF_FFFF);
            rd(8'(16 * (c + 1) + 8)); chk("R1 ctrl", got, 32'h0);
        end

        // R10 unmapped addresses
        wr(8'h1C, 32'h55); chk("R10 spare word", got, 32'h0);
        wr(8'h0C, 32'h7);  chk("R10 spare in run slot", got, 32'h0);
        wr(8'h40, 32'h99); chk("R10 slot past last channel", got, 32'h0);
        wr(8'h11, 32'h5);  chk("R10 misaligned", got, 32'h0);
        rd(8'h10); chk("R10 count untouched", got, 32'hFFFF_FFFF);
        rd(8'h00); chk("R10 run untouched", got, 32'h0);
        wr(8'h18, 32'hFFFF_FFF9); chk("R10 ctrl reserved bits", got, 32'h0000_0121 & 32'h0000_0021);

        // R4 prescaler: divide by 16, first tick a full period after start
        wr(8'h18, 32'h1);  chk("R4 select write", got, 32'h1);
        wr(8'h10, 32'd10); chk("R7 count write", got, 32'd10);
        wr(8'h00, 32'h1);  chk("R3 run bit 0", got, 32'h1);
        bus_addr = 8'h10;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #6;
            chk("R4 divide by 16", bus_rdata, 32'(10 - k / 16));
        end

        // R3 freeze
        wr(8'h00, 32'h0); chk("R3 run cleared", got, 32'h0);
        rd(8'h10); v1 = got; chk("R3 value at stop", v1, 32'd8);
        repeat (40) @(posedge clk);
        rd(8'h10); chk("R3 frozen", got, v1);

        // R7 direct count write
        wr(8'h10, 32'd7); chk("R7 stopped write", got, 32'd7);

        // R2 underflow reload and continue
        wr(8'h14, 32'd5); chk("R10 reload write", got, 32'd5);
        wr(8'h18, 32'h0); chk("R4 select 0", got, 32'h0);
        wr(8'h10, 32'd1); chk("R7 count preset", got, 32'd1);
        wr(8'h00, 32'h1); chk("R3 restart ch0", got, 32'h1);
        bus_addr = 8'h10;
        repeat (9) @(posedge clk); #6;
        chk("R2 reloaded after underflow", bus_rdata, 32'd5);
        wr(8'h10, 32'h1234); chk("R7 running write", got, 32'h1234);
        rd(8'h18); chk("R5 flag set by underflow", got, 32'h100);
        wr(8'h00, 32'h0);

        // R5 / R6 / R9 on channel 1: clear collides with underflow
        wr(8'h20, 32'h0);  chk("R7 ch1 count", got, 32'h0);
        wr(8'h24, 32'h0);  chk("R9 ch1 reload zero", got, 32'h0);
        wr(8'h28, 32'h20); chk("R6 enable set", got, 32'h20);
        wr(8'h00, 32'h2);  chk("R3 run bit 1", got, 32'h2);
        for (int k = 1; k <= 3; k++) begin
            wr(8'h28, 32'h20); chk("R5 no flag before first tick", got, 32'h20);
        end
        wr(8'h28, 32'h20); chk("R5 set wins over clear", got, 32'h120);
        chk("R6 irq high", {29'd0, irq}, 32'h2);
        bus_addr = 8'h20;
        repeat (30) @(posedge clk); #6;
        chk("R9 one-shot stays zero", bus_rdata, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h28, 32'h120); chk("R5 write one keeps flag", got, 32'h120);
        chk("R6 irq still high", {29'd0, irq}, 32'h2);
        wr(8'h28, 32'h100); chk("R6 enable off", got, 32'h100);
        chk("R6 irq low without enable", {29'd0, irq}, 32'h0);
        wr(8'h28, 32'h0);   chk("R5 write zero clears", got, 32'h0);

        // R8 free-running wrap on channel 2
        wr(8'h30, 32'd2); chk("R7 ch2 count", got, 32'd2);
        wr(8'h38, 32'h0); chk("R4 ch2 select 0", got, 32'h0);
        wr(8'h00, 32'h4); chk("R3 run bit 2", got, 32'h4);
        bus_addr = 8'h30;
        repeat (13) @(posedge clk); #6;
        chk("R8 wrap to all ones", bus_rdata, 32'hFFFF_FFFF);
        rd(8'h38); chk("R5 ch2 flag on wrap", got, 32'h100);
        wr(8'h00, 32'h0);
        repeat (4) @(posedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule